// File: doc/BRIEF.md
# Stochastic Ring Reservoir with Shared Stream Sources

This block is a recurrent reservoir of N neurons wired as a single loop. Each neuron does its weighting and summing in the probabilistic domain. Binary words are turned into one-bit streams by comparing them against pseudorandom words. The streams are multiplied with XNOR gates and mixed with a multiplexer. The ones in the mixed stream are counted over an evaluation window. At the end of the window a saturating activation turns the count back into a binary state word. Neurons pass binary state words to each other, not streams. Because of that, one small bank of LFSR sources and the comparators for the input and the fixed weights serve every neuron. Only the comparator for the predecessor state is built once per neuron.

The block takes one input sample word at a time. A controller runs one reservoir time step per window and latches all new states on the same edge. A binary readout then forms a weighted sum of the states using 8-bit output weights supplied from outside. Once the start-up transient has passed, each new readout value comes with a one-cycle valid pulse.

Top module: `sc_ring_reservoir`

## Requirements
- R1: Neuron i reads the state of neuron i-1 as its ring input, and neuron 0 reads the state of neuron N-1.
- R2: Four 26-bit LFSRs shift left and feed in q[25]^q[5]^q[1]^q[0]. Generator g resets to 26'h2A5F3C1 ^ (g*26'h135791). No generator ever holds zero.
- R3: Comparators use the low WB bits of the generators. The input stream bit is sample_i > rnd0, the state stream bit is pred > rnd1, the input-weight bit is W_IN > rnd2 and the ring-weight bit is W_RING > rnd3. The input product is the XNOR of the input and input-weight bits, inverted when IN_SIGN[i] is 1. The ring product is the XNOR of the state and ring-weight bits. The mixed bit is the ring product when the XOR of the four generators' bit 25 is 1, and the input product otherwise.
- R4: A window lasts L = 2^WB cycles. The count c is the number of mixed ones over those L cycles, including the last cycle.
- R5: The new state is clamp(2c - L/2, 0, L-1), taken as an offset-binary word in which L/2 means zero.
- R6: All states change on one edge, only at the end of a window, and each is computed from the values held before that edge.
- R7: One edge after a state update, y_o is loaded with the sum of (x_i - L/2) * w_i. Here w_i is the signed byte w_out_i[8i+7:8i], read on that edge. y_o holds its value between loads.
- R8: valid_o stays low for the first TRANSIENT time steps. After that it pulses for one cycle with each y_o load.
- R9: y_o has WB+8+clog2(N) bits, so no combination of states and weights overflows it, including every weight at -128.
- R10: Under reset every state is L/2, y_o is 0 and valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | WB | External input sample, offset binary |
| w_out_i | input | 8*N | Signed output weights, one byte per neuron |
| state_o | output | WB*N | Neuron states, neuron i in bits [WB*i +: WB] |
| y_o | output | WB+8+clog2(N) | Signed readout sum |
| valid_o | output | 1 | One-cycle pulse with each readout after the transient |

## Verification
The hardest conditions to reach from the ports are the two clamp limits of the activation and the edge where the transient ends. The transient edge is only reached after TRANSIENT+1 full windows. The bench therefore shrinks the window to 64 cycles and runs 28 steps. To drive counts toward both clamp limits, it holds the sample at full scale and at zero for several windows each, with mixed input signs across the neurons. The readout is tested at its extremes by switching every weight to -128 and then to +127 late in the run. A behavioural model tracks streams, counts, states and readout every cycle, and the bench compares against it.

// File: rtl/sc_rr_pkg.sv
`timescale 1ns/1ps
package sc_rr_pkg;
  localparam int LFSR_W   = 26;
  localparam int NUM_GEN  = 4;
  localparam int WOUT_W   = 8;
  localparam int GEN_IN   = 0;
  localparam int GEN_ST   = 1;
  localparam int GEN_WIN  = 2;
  localparam int GEN_WR   = 3;

  typedef logic [LFSR_W-1:0] lfsr_t;

  function automatic lfsr_t seed_of(input int g);
    return 26'h2A5F3C1 ^ lfsr_t'(g * 32'h0135791);
  endfunction

  function automatic lfsr_t lfsr_next(input lfsr_t q);
    return {q[LFSR_W-2:0], q[25] ^ q[5] ^ q[1] ^ q[0]};
  endfunction
endpackage

// File: rtl/sc_rr_lfsr.sv
`timescale 1ns/1ps
module sc_rr_lfsr
  import sc_rr_pkg::*;
#(
  parameter int    WB   = 16,
  parameter lfsr_t SEED = 26'h1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [WB-1:0] rnd_o,
  output logic          top_o
);
  lfsr_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else         q <= lfsr_next(q);
  end

  assign rnd_o = q[WB-1:0];
  assign top_o = q[LFSR_W-1];

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) q != '0); // R2
endmodule

// File: rtl/sc_rr_ctrl.sv
`timescale 1ns/1ps
module sc_rr_ctrl #(
  parameter int WB        = 16,
  parameter int TRANSIENT = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic win_end_o,
  output logic go_o,
  output logic keep_o
);
  localparam int SC_W = $clog2(TRANSIENT + 2);
  localparam logic [SC_W-1:0] LAST = SC_W'(TRANSIENT);

  logic [WB-1:0]   win_q;
  logic [SC_W-1:0] step_q;
  logic            go_q;

  assign win_end_o = &win_q;
  assign go_o      = go_q;
  assign keep_o    = step_q > LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      step_q <= '0;
      go_q   <= 1'b0;
    end else begin
      win_q <= win_q + 1'b1;
      go_q  <= win_end_o;
      if (win_end_o && step_q <= LAST) step_q <= step_q + 1'b1;
    end
  end

  AST_SINGLE_WIN_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_o |=> !win_end_o); // R4
  AST_STEP_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keep_o |=> keep_o); // R8
endmodule

// File: rtl/sc_rr_neuron.sv
`timescale 1ns/1ps
module sc_rr_neuron #(
  parameter int WB  = 16,
  parameter bit NEG = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          win_end_i,
  input  logic          in_prod_i,
  input  logic          ring_w_bit_i,
  input  logic          sel_i,
  input  logic [WB-1:0] rnd_i,
  input  logic [WB-1:0] pred_i,
  output logic [WB-1:0] state_o
);
  localparam int L  = 1 << WB;
  localparam int CW = WB + 1;
  localparam int AW = WB + 3;
  localparam logic signed [AW-1:0] HALF = AW'(L / 2);
  localparam logic signed [AW-1:0] MAXV = AW'(L - 1);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic [WB-1:0] state_q, state_nx;
  logic signed [AW-1:0] act;
  logic pred_bit, ring_bit, in_bit, mix_bit;

  assign pred_bit = pred_i > rnd_i;
  assign ring_bit = ~(pred_bit ^ ring_w_bit_i);
  assign in_bit   = in_prod_i ^ NEG;
  assign mix_bit  = sel_i ? ring_bit : in_bit;
  assign cnt_nx   = cnt_q + CW'(mix_bit);

  always_comb begin
    act = $signed({1'b0, cnt_nx, 1'b0}) - HALF;
    if (act < 0)         state_nx = '0;
    else if (act > MAXV) state_nx = '1;
    else                 state_nx = act[WB-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      state_q <= {1'b1, {(WB-1){1'b0}}};
    end else if (win_end_i) begin
      cnt_q   <= '0;
      state_q <= state_nx;
    end else begin
      cnt_q   <= cnt_nx;
    end
  end

  assign state_o = state_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(L)); // R4
endmodule

// File: rtl/sc_rr_readout.sv
`timescale 1ns/1ps
module sc_rr_readout #(
  parameter int N  = 4,
  parameter int WB = 16,
  parameter int AW = 22
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 go_i,
  input  logic                 keep_i,
  input  logic [N*WB-1:0]      state_i,
  input  logic [N*8-1:0]       w_i,
  output logic signed [AW-1:0] y_o,
  output logic                 valid_o
);
  logic signed [AW-1:0] acc, y_q;
  logic                 valid_q;

  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) begin
      logic signed [WB-1:0]   xs;
      logic signed [7:0]      ws;
      logic signed [WB+7:0]   prod;
      xs   = {~state_i[i*WB+WB-1], state_i[i*WB +: WB-1]};
      ws   = w_i[i*8 +: 8];
      prod = xs * ws;
      acc  = acc + AW'(prod);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q     <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= go_i & keep_i;
      if (go_i) y_q <= acc;
    end
  end

  assign y_o     = y_q;
  assign valid_o = valid_q;

  AST_NO_EARLY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> keep_i); // R8
  AST_Y_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(go_i) |-> $stable(y_o)); // R7
endmodule

// File: rtl/sc_ring_reservoir.sv
`timescale 1ns/1ps
module sc_ring_reservoir
  import sc_rr_pkg::*;
#(
  parameter int          N         = 4,
  parameter int          WB        = 16,
  parameter int          TRANSIENT = 20,
  parameter int          W_IN      = 3 << (WB - 2),
  parameter int          W_RING    = 5 << (WB - 3),
  parameter logic [31:0] IN_SIGN   = 32'h6
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [WB-1:0]                       sample_i,
  input  logic [N*8-1:0]                      w_out_i,
  output logic [N*WB-1:0]                     state_o,
  output logic signed [WB+8+$clog2(N)-1:0]    y_o,
  output logic                                valid_o
);
  localparam int Y_W = WB + 8 + $clog2(N);
  localparam logic [WB-1:0] W_IN_W   = WB'(W_IN);
  localparam logic [WB-1:0] W_RING_W = WB'(W_RING);

  logic [WB-1:0]      rnd [NUM_GEN];
  logic [NUM_GEN-1:0] top_bit;
  logic               win_end, go, keep;
  logic               u_bit, win_bit, wr_bit, in_prod, sel;
  logic [N*WB-1:0]    state;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    sc_rr_lfsr #(.WB(WB), .SEED(seed_of(g))) u_lfsr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rnd_o  (rnd[g]),
      .top_o  (top_bit[g])
    );
  end

  // comparators shared by every neuron
  assign u_bit   = sample_i > rnd[GEN_IN];
  assign win_bit = W_IN_W   > rnd[GEN_WIN];
  assign wr_bit  = W_RING_W > rnd[GEN_WR];
  assign in_prod = ~(u_bit ^ win_bit);
  assign sel     = ^top_bit;

  sc_rr_ctrl #(.WB(WB), .TRANSIENT(TRANSIENT)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_end_o (win_end),
    .go_o      (go),
    .keep_o    (keep)
  );

  for (genvar i = 0; i < N; i++) begin : g_neuron
    localparam int P = (i + N - 1) % N;
    sc_rr_neuron #(.WB(WB), .NEG(IN_SIGN[i])) u_neuron (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .win_end_i    (win_end),
      .in_prod_i    (in_prod),
      .ring_w_bit_i (wr_bit),
      .sel_i        (sel),
      .rnd_i        (rnd[GEN_ST]),
      .pred_i       (state[P*WB +: WB]),
      .state_o      (state[i*WB +: WB])
    );
  end

  sc_rr_readout #(.N(N), .WB(WB), .AW(Y_W)) u_readout (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go),
    .keep_i  (keep),
    .state_i (state),
    .w_i     (w_out_i),
    .y_o     (y_o),
    .valid_o (valid_o)
  );

  assign state_o = state;

  AST_SYNC_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != $past(state)) |-> $past(win_end)); // R6
  AST_VALID_AFTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(go)); // R8
endmodule

// File: tb/tb_sc_ring_reservoir.sv
`timescale 1ns/1ps
module tb_sc_ring_reservoir;
  localparam int N = 4, WB = 6, L = 64, TR = 20, WIN = 48, WR = 40;
  localparam logic [31:0] SGN = 32'h6;
  localparam int STEPS = 28;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [WB-1:0] sample = '0;
  logic [N*8-1:0] w_out = '0;
  logic [N*WB-1:0] state_o;
  logic signed [15:0] y_o;
  logic valid_o;
  int total = 0, bad = 0, valid_seen = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sc_ring_reservoir #(.N(N), .WB(WB), .TRANSIENT(TR), .W_IN(WIN), .W_RING(WR), .IN_SIGN(SGN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .w_out_i(w_out),
    .state_o(state_o), .y_o(y_o), .valid_o(valid_o));

  // behavioural reference
  logic [25:0] m_l [4];
  int m_x [N], m_c [N], m_win, m_step, m_y;
  bit m_go, m_valid;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < 4; g++) m_l[g] = 26'h2A5F3C1 ^ 26'(g * 'h135791);
      for (int i = 0; i < N; i++) begin m_x[i] = L/2; m_c[i] = 0; end
      m_win = 0; m_step = 0; m_y = 0; m_go = 0; m_valid = 0;
    end else begin
      int r0, r1, r2, r3, nc [N];
      bit sel, ub, wb, rb;
      r0 = int'(m_l[0][5:0]); r1 = int'(m_l[1][5:0]);
      r2 = int'(m_l[2][5:0]); r3 = int'(m_l[3][5:0]);
      sel = m_l[0][25] ^ m_l[1][25] ^ m_l[2][25] ^ m_l[3][25];
      ub = int'(sample) > r0; wb = WIN > r2; rb = WR > r3;
      for (int i = 0; i < N; i++) begin
        bit xb, sr, si;
        xb = m_x[(i + N - 1) % N] > r1;
        sr = (xb == rb);
        si = (ub == wb) ^ SGN[i];
        nc[i] = m_c[i] + int'(sel ? sr : si);
      end
      if (m_go) begin
        m_y = 0;
        for (int i = 0; i < N; i++) m_y += (m_x[i] - L/2) * int'($signed(w_out[i*8 +: 8]));
        m_valid = m_step > TR;
      end else m_valid = 0;
      if (m_win == L - 1) begin
        for (int i = 0; i < N; i++) begin
          int v;
          v = 2 * nc[i] - L/2;
          m_x[i] = v < 0 ? 0 : (v > L - 1 ? L - 1 : v);
          m_c[i] = 0;
        end
        m_step++; m_go = 1;
      end else begin
        for (int i = 0; i < N; i++) m_c[i] = nc[i];
        m_go = 0;
      end
      m_win = (m_win + 1) % L;
      for (int g = 0; g < 4; g++) m_l[g] = {m_l[g][24:0], m_l[g][25] ^ m_l[g][5] ^ m_l[g][1] ^ m_l[g][0]};
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic drive(input int cyc);
    int w;
    w = cyc / L;
    if (w < 6)       sample = WB'((cyc * 5) % L);
    else if (w < 12) sample = WB'(L - 1);
    else if (w < 16) sample = '0;
    else if (w < 22) sample = (w % 2) ? WB'(L - 1) : '0;
    else             sample = WB'((cyc * 7) % L);
    if (w < 22)      w_out = {8'sd100, -8'sd37, 8'sd5, -8'sd128};
    else if (w < 25) w_out = {4{-8'sd128}};   // R9 extreme
    else             w_out = {4{8'sd127}};
  endtask

  initial begin
    drive(0);
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++)
      chk(state_o[i*WB +: WB] == WB'(L/2), "R10 reset state", int'(state_o[i*WB +: WB]), L/2);
    chk(y_o == 0, "R10 reset y", int'(y_o), 0);
    chk(valid_o == 0, "R10 reset valid", int'(valid_o), 0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < STEPS * L + 4; cyc++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++)
        chk(int'(state_o[i*WB +: WB]) == m_x[i], $sformatf("R1 R2 R3 R4 R5 R6 state%0d", i),
            int'(state_o[i*WB +: WB]), m_x[i]);
      chk(int'(y_o) == m_y, "R7 R9 readout", int'(y_o), m_y);
      chk(valid_o == m_valid, "R8 valid", int'(valid_o), int'(m_valid));
      if (valid_o) begin
        valid_seen++;
        chk(cyc >= (TR + 1) * L, "R8 no valid in transient", cyc, (TR + 1) * L);
      end
      drive(cyc + 1);
    end
    chk(valid_seen == STEPS - TR, "R8 valid pulse count", valid_seen, STEPS - TR);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule